// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Deadtime

This block drives the six gate signals of a three-phase bridge. A 16-bit rate value is summed into an accumulator on every system clock, and each carry out of that sum is one PWM tick. The ticks step an 11-bit counter. The counter is folded into a symmetric up/down triangle, so the waveform is centre aligned and one PWM period lasts 2048 ticks. Each phase compares its own 10-bit offset-binary duty against the triangle. The result drives a complementary high/low pair. Whenever that pair changes state, the output that is turning on is held off for a programmable deadtime.

A fault input, whose active level can be selected, removes the enable and is latched. While the block is not enabled, all six gate outputs and the amplifier-enable output are low. A one-cycle strobe marks a programmable point in each period, so that a control loop can sample its currents there. Software reaches the block over a small word-addressed register bus with four registers: packed duties, enable/status, setup and rate. The duty and setup registers are double buffered, so a period never starts with one set of values and finishes with another.

Top module: `p3pwm_top`

## Requirements
- R1: The rate register (word 3, bits 15:0) is added into a 16-bit accumulator every clock, and each carry out advances the period counter by one tick. Rate 32768 gives a period of 4096 clocks, rate 16384 gives 8192 clocks, and rate 0 stops the counter.
- R2: The 11-bit counter is folded into a 10-bit triangle: the lower 10 bits, inverted when bit 10 is set. A phase's raw drive is high while its duty is greater than the triangle, so with zero deadtime the high output is on for 2·duty ticks out of every 2048.
- R3: The value register (word 0) packs the phase A duty in bits 9:0, phase B in bits 19:10 and phase C in bits 29:20. Each duty is offset binary, with 512 as the midpoint. Bits 31:30 read back as zero.
- R4: The setup register (word 2) holds the deadtime in bits 8:0, the fault polarity in bit 15 and the sample position in bits 25:16. All other bits read back as zero.
- R5: A phase's high and low outputs are never on together. After each change of the raw drive, the output that is turning on stays off for 2·deadtime ticks, so each output loses 2·deadtime ticks per period.
- R6: While the enable state is 0, all six gate outputs and amp_en are low.
- R7: Writing 1 to bit 0 of word 1 enables the block, provided no fault is present at that moment. A fault clears the enable and sets a latched fault flag. The flag reads back in bit 1 and the enable state reads back in bit 0. The flag clears only when 1 is written to bit 0 while the fault is absent.
- R8: With fault polarity 0 the fault input is active low. With polarity 1 it is active high.
- R9: sample_strobe is high for exactly one clock per period, at the point where the counter equals twice the sample position.
- R10: Duty and setup writes are visible on readback at once, but they take effect on the outputs only when the next period starts, that is, when the counter wraps to 0.
- R11: The register word offsets are value 0, enable/status 1, setup 2 and rate 3. After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fault_in | input | 1 | External fault input; its active level is set by the polarity bit |
| amp_en | output | 1 | Amplifier enable, the current enable state |
| gate_hi | output | 3 | High-side gate drive for phases C,B,A (bit 0 = A) |
| gate_lo | output | 3 | Low-side gate drive for phases C,B,A (bit 0 = A) |
| sample_strobe | output | 1 | One-clock pulse at the programmed sample point |

## Verification
The duty comparison is tested with three different duties at once: 256, the midpoint 512, and 768. Counting high and low clocks over one whole period shows whether the triangle folds correctly and whether each phase reads its own field. The extreme duties 0 and 1023 test the edges of the comparison: one leaves the high side always off, the other leaves a 4-clock low notch. Repeating the mixed pattern with deadtime 10 separates correct blanking from blanking that is missing, or applied to the wrong side or with the wrong length. Writing a duty just after a period starts shows whether the change waits for the next period. A fault raised and removed under both polarity settings shows whether the flag is held and whether the enable request is refused while the fault is present.

// File: rtl/p3pwm_pkg.sv
package p3pwm_pkg;
    localparam int NUM_PH    = 3;
    localparam int RATE_W    = 16;
    localparam int CNT_W     = 11;
    localparam int DUTY_W    = CNT_W - 1;
    localparam int DT_W      = 9;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int VAL_W     = NUM_PH * DUTY_W;
    // setup word field positions
    localparam int DEAD_LSB  = 0;
    localparam int POL_BIT   = 15;
    localparam int SAMP_LSB  = 16;
    // register word offsets
    localparam logic [ADDR_W-1:0] A_VALUE = 2'd0;
    localparam logic [ADDR_W-1:0] A_ENSTS = 2'd1;
    localparam logic [ADDR_W-1:0] A_SETUP = 2'd2;
    localparam logic [ADDR_W-1:0] A_RATE  = 2'd3;

    typedef struct packed {
        logic [DUTY_W-1:0] samp;
        logic              pol;
        logic [DT_W-1:0]   dead;
    } setup_t;
endpackage

// File: rtl/p3pwm_timebase.sv
module p3pwm_timebase #(
    parameter int RATE_W = p3pwm_pkg::RATE_W,
    parameter int CNT_W  = p3pwm_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              tick,
    output logic              wrap,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_nx
);
    typedef struct packed {
        logic [RATE_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
    } tb_st_t;

    tb_st_t st_d, st_q;
    logic [RATE_W:0] sum;

    always_comb begin
        st_d     = st_q;
        sum      = {1'b0, st_q.acc} + {1'b0, rate};
        tick     = sum[RATE_W];
        st_d.acc = sum[RATE_W-1:0];
        if (tick) st_d.cnt = st_q.cnt + 1'b1;
        wrap     = tick && (&st_q.cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q  = st_q.cnt;
    assign cnt_nx = st_d.cnt;
endmodule

// File: rtl/p3pwm_leg.sv
module p3pwm_leg #(
    parameter int DUTY_W = p3pwm_pkg::DUTY_W,
    parameter int DT_W   = p3pwm_pkg::DT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic [DUTY_W-1:0] duty_nx,
    input  logic [DUTY_W-1:0] tri_nx,
    input  logic [DT_W-1:0]   dead,
    output logic              out_hi,
    output logic              out_lo
);
    localparam int BLK_W = DT_W + 1;

    typedef struct packed {
        logic             raw;
        logic [BLK_W-1:0] blank;
    } leg_st_t;

    leg_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.raw = duty_nx > tri_nx;
        if (st_d.raw != st_q.raw)
            st_d.blank = {dead, 1'b0};
        else if (tick && (st_q.blank != '0))
            st_d.blank = st_q.blank - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_hi = enable &&  st_q.raw && (st_q.blank == '0);
    assign out_lo = enable && !st_q.raw && (st_q.blank == '0);
endmodule

// File: rtl/p3pwm_top.sv
module p3pwm_top
    import p3pwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                fault_in,
    output logic                amp_en,
    output logic [NUM_PH-1:0]   gate_hi,
    output logic [NUM_PH-1:0]   gate_lo,
    output logic                sample_strobe
);
    typedef struct packed {
        logic [VAL_W-1:0]  val_sh;
        logic [VAL_W-1:0]  val_act;
        setup_t            su_sh;
        setup_t            su_act;
        logic [RATE_W-1:0] rate;
        logic              en;
        logic              flt;
        logic              strobe;
    } top_st_t;

    top_st_t cur_q, cur_d;

    logic              tick, wrap, fault_act;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic [DUTY_W-1:0] tri_nx;
    logic [VAL_W-1:0]  val_nx;
    setup_t            su_nx;

    p3pwm_timebase #(.RATE_W(RATE_W), .CNT_W(CNT_W)) tb_i (
        .clk(clk), .rst_n(rst_n), .rate(cur_q.rate),
        .tick(tick), .wrap(wrap), .cnt_q(cnt_q), .cnt_nx(cnt_nx)
    );

    always_comb begin
        tri_nx = cnt_nx[CNT_W-1] ? ~cnt_nx[DUTY_W-1:0] : cnt_nx[DUTY_W-1:0];
        val_nx = wrap ? cur_q.val_sh : cur_q.val_act;
        su_nx  = wrap ? cur_q.su_sh  : cur_q.su_act;
    end

    always_comb begin
        cur_d     = cur_q;
        fault_act = cur_q.su_act.pol ? fault_in : !fault_in;

        if (bus_wr) begin
            unique case (bus_addr)
                A_VALUE: cur_d.val_sh = bus_wdata[VAL_W-1:0];
                A_ENSTS: begin
                    if (!bus_wdata[0])
                        cur_d.en = 1'b0;
                    else if (!fault_act) begin
                        cur_d.en  = 1'b1;
                        cur_d.flt = 1'b0;
                    end
                end
                A_SETUP: begin
                    cur_d.su_sh.dead = bus_wdata[DEAD_LSB +: DT_W];
                    cur_d.su_sh.pol  = bus_wdata[POL_BIT];
                    cur_d.su_sh.samp = bus_wdata[SAMP_LSB +: DUTY_W];
                end
                A_RATE:  cur_d.rate = bus_wdata[RATE_W-1:0];
                default: ;
            endcase
        end

        if (fault_act) begin
            cur_d.flt = 1'b1;
            cur_d.en  = 1'b0;
        end

        cur_d.val_act = val_nx;
        cur_d.su_act  = su_nx;
        cur_d.strobe  = tick && (cnt_nx == {su_nx.samp, 1'b0});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    for (genvar g = 0; g < NUM_PH; g++) begin : g_leg
        p3pwm_leg #(.DUTY_W(DUTY_W), .DT_W(DT_W)) leg_i (
            .clk(clk), .rst_n(rst_n), .tick(tick), .enable(cur_q.en),
            .duty_nx(val_nx[g*DUTY_W +: DUTY_W]), .tri_nx(tri_nx),
            .dead(su_nx.dead), .out_hi(gate_hi[g]), .out_lo(gate_lo[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_VALUE: bus_rdata[VAL_W-1:0] = cur_q.val_sh;
            A_ENSTS: bus_rdata[1:0] = {cur_q.flt, cur_q.en};
            A_SETUP: begin
                bus_rdata[DEAD_LSB +: DT_W]   = cur_q.su_sh.dead;
                bus_rdata[POL_BIT]            = cur_q.su_sh.pol;
                bus_rdata[SAMP_LSB +: DUTY_W] = cur_q.su_sh.samp;
            end
            A_RATE:  bus_rdata[RATE_W-1:0] = cur_q.rate;
            default: ;
        endcase
    end

    assign amp_en        = cur_q.en;
    assign sample_strobe = cur_q.strobe;
endmodule

// File: rtl/p3pwm_checker.sv
module p3pwm_checker
    import p3pwm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_PH-1:0] gate_hi,
    input logic [NUM_PH-1:0] gate_lo,
    input logic              amp_en,
    input logic              strobe,
    input logic              fault_latched,
    input logic [RATE_W-1:0] rate,
    input logic [CNT_W-1:0]  cnt
);
    // R5: complementary pair never on at once
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    // R6: nothing driven while disabled
    assert_off_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_en |-> (gate_hi == '0 && gate_lo == '0));

    // R7: latched fault vetoes enable
    assert_fault_vetoes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> !amp_en);

    // R9: strobe lasts one clock
    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R1: zero rate freezes the counter
    assert_rate_zero_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == '0) |=> $stable(cnt));
endmodule

bind p3pwm_top p3pwm_checker chk_i (
    .clk(clk), .rst_n(rst_n), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .amp_en(amp_en), .strobe(sample_strobe), .fault_latched(cur_q.flt),
    .rate(cur_q.rate), .cnt(cnt_q)
);

// File: tb/p3pwm_top_tb_top.sv
module p3pwm_top_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  PER_CLKS   = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fault_in = 1'b1;
    logic        amp_en;
    logic [2:0]  gate_hi, gate_lo;
    logic        sample_strobe;

    int checks = 0;
    int errors = 0;
    int hi_c[3];
    int lo_c[3];
    int st_c;

    always #(CLK_PERIOD/2) clk = ~clk;

    p3pwm_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_in(fault_in),
        .amp_en(amp_en), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .sample_strobe(sample_strobe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic measure();
        for (int p = 0; p < 3; p++) begin hi_c[p] = 0; lo_c[p] = 0; end
        st_c = 0;
        for (int i = 0; i < PER_CLKS; i++) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) begin
                hi_c[p] += int'(gate_hi[p]);
                lo_c[p] += int'(gate_lo[p]);
            end
            st_c += int'(sample_strobe);
        end
    endtask

    function automatic logic [31:0] pack(input int a, input int b, input int c);
        return (32'(c) << 20) | (32'(b) << 10) | 32'(a);
    endfunction

    task automatic settle();
        repeat (2*PER_CLKS + 16) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        check("R6", "amp_en after reset", int'(amp_en), 0);
        check("R6", "gates after reset", int'({gate_hi, gate_lo}), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R11", $sformatf("reg %0d after reset", a), int'(d), 0);
        end
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d);
        check("R3", "value readback", int'(d), 32'h3FFF_FFFF);
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d);
        check("R4", "setup readback", int'(d), 32'h03FF_81FF);
        wr(2'd3, 32'h1234_ABCD); rd(2'd3, d);
        check("R11", "rate readback", int'(d), 32'h0000_ABCD);
        wr(2'd2, 32'h0);
        wr(2'd3, 32'd32768);
        wr(2'd1, 32'd1); rd(2'd1, d);
        check("R7", "enable readback", int'(d), 1);
    endtask

    task automatic t_duty_mix();
        wr(2'd0, pack(512, 256, 768));
        settle(); measure();
        check("R2", "A hi (512)", hi_c[0], 2048);
        check("R2", "B hi (256)", hi_c[1], 1024);
        check("R3", "C hi (768)", hi_c[2], 3072);
        check("R2", "B lo (256)", lo_c[1], 3072);
        check("R9", "strobes per period", st_c, 1);
    endtask

    task automatic t_deadtime();
        wr(2'd2, 32'd10);
        settle(); measure();
        check("R5", "A hi dt10", hi_c[0], 2008);
        check("R5", "A lo dt10", lo_c[0], 2008);
        check("R5", "B hi dt10", hi_c[1], 984);
        check("R5", "B lo dt10", lo_c[1], 3032);
        check("R5", "C hi dt10", hi_c[2], 3032);
        wr(2'd2, 32'd0);
    endtask

    task automatic t_extremes();
        wr(2'd0, pack(0, 1023, 512));
        wr(2'd2, 32'(300) << 16);
        settle(); measure();
        check("R2", "A hi duty0", hi_c[0], 0);
        check("R2", "A lo duty0", lo_c[0], 4096);
        check("R2", "B hi duty1023", hi_c[1], 4092);
        check("R2", "B lo duty1023", lo_c[1], 4);
        check("R9", "strobes per period at pos 300", st_c, 1);
        wr(2'd2, 32'd0);
        wr(2'd0, pack(512, 512, 512));
        settle();
    endtask

    task automatic t_double_buffer();
        logic [31:0] d;
        int a_hi = 0;
        @(negedge clk);
        while (!sample_strobe) @(negedge clk);
        for (int i = 0; i < PER_CLKS; i++) begin
            if (i == 0) begin bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = pack(256, 512, 512); end
            if (i == 1) bus_wr = 1'b0;
            a_hi += int'(gate_hi[0]);
            @(negedge clk);
        end
        check("R10", "A hi in period of write (old duty)", a_hi, 2048);
        rd(2'd0, d);
        check("R10", "value readback immediate", int'(d), int'(pack(256, 512, 512)));
        measure();
        check("R10", "A hi next period (new duty)", hi_c[0], 1024);
    endtask

    task automatic t_disable();
        int on = 0;
        wr(2'd1, 32'd0);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            on += int'(gate_hi != 0) + int'(gate_lo != 0) + int'(amp_en);
        end
        check("R6", "outputs while disabled", on, 0);
        wr(2'd1, 32'd1);
    endtask

    task automatic t_fault();
        logic [31:0] d;
        @(negedge clk); fault_in = 1'b0;
        @(negedge clk);
        check("R7", "amp_en on fault", int'(amp_en), 0);
        check("R6", "gates on fault", int'({gate_hi, gate_lo}), 0);
        rd(2'd1, d);
        check("R7", "status during fault", int'(d), 2);
        wr(2'd1, 32'd1); rd(2'd1, d);
        check("R7", "enable refused while fault", int'(d), 2);
        fault_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd1, d);
        check("R7", "fault stays latched", int'(d), 2);
        wr(2'd1, 32'd1); rd(2'd1, d);
        check("R7", "re-enable clears flag", int'(d), 1);
    endtask

    task automatic t_polarity();
        logic [31:0] d;
        wr(2'd2, 32'h0000_8000);
        settle();
        rd(2'd1, d);
        check("R8", "high input is fault with pol 1", int'(d), 2);
        fault_in = 1'b0;
        wr(2'd1, 32'd1); rd(2'd1, d);
        check("R8", "low input clear with pol 1", int'(d), 1);
        @(negedge clk); fault_in = 1'b1;
        @(negedge clk);
        check("R8", "amp_en drops on high input", int'(amp_en), 0);
    endtask

    task automatic t_rate();
        int gap;
        wr(2'd3, 32'd16384);
        settle(); settle();
        @(negedge clk);
        while (!sample_strobe) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!sample_strobe);
        check("R1", "period at rate 16384", gap, 8192);
        wr(2'd3, 32'd32768);
        settle();
        while (!sample_strobe) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!sample_strobe);
        check("R1", "period at rate 32768", gap, 4096);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_duty_mix();
        t_deadtime();
        t_extremes();
        t_double_buffer();
        t_disable();
        t_fault();
        t_polarity();
        t_rate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule